// File: doc/BRIEF.md
# GCI Highway Timeslot Transceiver

This block connects one device to a compressed-mode GCI highway. Each frame holds eight 32-bit timeslots, and the device owns exactly one of them, chosen by `slot_sel`. During its own slot the block shifts out a 32-bit word upstream, MSB first. The word is built from two voice bytes, a monitor byte, a six-bit C/I field and the two handshake flags. In the same slot it collects the downstream word with the same layout and hands the fields to the parallel side.

The whole block runs on the highway data clock. It measures how many clock edges fall between consecutive frame syncs, which tells it whether the clock runs at one or two times the line bit rate. In the double-rate case every line bit spans two clock cycles. A frame sync that arrives at any other count marks a framing error and restarts bit counting. Companding, filtering and the monitor message protocol belong to other blocks.

Top module: `gci_slot_xcvr`

## Requirements
- R1: A rising `bit_clk` edge that sees `frame_sync` high is bit position 0 of a new frame. Slot `s` occupies line bits `32*s` to `32*s+31`, counted from that edge. The first bit of the owned slot appears on `up_data` right after the rising edge that starts it.
- R2: A slot word goes out and comes in MSB first. Bits 31..24 are voice A, 23..16 voice B, 15..8 monitor, 7..2 the C/I field (bit 7 is C/I bit 5), bit 1 is MR and bit 0 is MX. So MR is the second-to-last bit and MX the last.
- R3: On the line MR and MX are active low. The ports `tx_mr`, `tx_mx`, `rx_mr` and `rx_mx` are active high, so a port value of 1 is carried as line bit 0.
- R4: `up_oe` is high only while the slot selected by `slot_sel` is on the line. At all other times `up_oe` is low and `up_data` rests at 1.
- R5: The transmit fields are captured at the rising edge that starts the owned slot. Changes to them later in that slot do not alter the bits sent.
- R6: `dn_data` is sampled on falling `bit_clk` edges. The rising edge after the last bit of the owned slot updates the receive fields and raises `rx_valid` for exactly one cycle. That edge may be the next frame's bit 0.
- R7: At each frame sync, a count of 256 clock edges since the previous sync selects single rate and a count of 512 selects double rate. The new rate applies from that sync onward and is shown on `rate_dbl` (1 = double). It changes at no other time.
- R8: At double rate, every line bit lasts two clock cycles. `up_data` changes only on rising edges at even positions from the sync. `dn_data` is taken on the falling edge of the second cycle of each bit.
- R9: A frame sync at any count other than 256 or 512 (except the first one after reset) sets `frame_err`. The flag holds until reset. The bit counter restarts and the rate is kept.
- R10: After reset, `up_oe`, `rx_valid`, `rate_dbl` and `frame_err` are 0, `up_data` is 1, and no slot is driven before the first frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Highway data clock, 1x or 2x the line bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | Frame sync, sampled on rising `bit_clk` |
| dn_data | input | 1 | Downstream serial data |
| slot_sel | input | 3 | Index of the owned timeslot |
| tx_voice_a | input | 8 | Upstream voice byte A |
| tx_voice_b | input | 8 | Upstream voice byte B |
| tx_mon | input | 8 | Upstream monitor byte |
| tx_ci | input | 6 | Upstream C/I field |
| tx_mr | input | 1 | Upstream MR request, active high |
| tx_mx | input | 1 | Upstream MX request, active high |
| up_data | output | 1 | Upstream serial data |
| up_oe | output | 1 | Output enable for the upstream pad |
| rx_voice_a | output | 8 | Received voice byte A |
| rx_voice_b | output | 8 | Received voice byte B |
| rx_mon | output | 8 | Received monitor byte |
| rx_ci | output | 6 | Received C/I field |
| rx_mr | output | 1 | Received MR, active high |
| rx_mx | output | 1 | Received MX, active high |
| rx_valid | output | 1 | One-cycle strobe: receive fields updated |
| rate_dbl | output | 1 | Detected clock rate, 1 = double |
| frame_err | output | 1 | Sticky framing error |

## Verification
The bench builds the block with the default of eight slots, so each frame is a full 256- or 512-edge frame. With that size the owned slot can be the last one, whose receive strobe lands on the next frame's sync edge. The bench steps the selected slot through first, middle and last positions. It switches the clock rate both ways, including the frame in which the new length is first measured. It also sends one late and one early sync, so the resync path and the sticky error are both exercised.

// File: rtl/gci_slot_xcvr.sv
module gci_slot_xcvr #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              dn_data,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic [7:0]        tx_voice_a,
  input  logic [7:0]        tx_voice_b,
  input  logic [7:0]        tx_mon,
  input  logic [5:0]        tx_ci,
  input  logic              tx_mr,
  input  logic              tx_mx,
  output logic              up_data,
  output logic              up_oe,
  output logic [7:0]        rx_voice_a,
  output logic [7:0]        rx_voice_b,
  output logic [7:0]        rx_mon,
  output logic [5:0]        rx_ci,
  output logic              rx_mr,
  output logic              rx_mx,
  output logic              rx_valid,
  output logic              rate_dbl,
  output logic              frame_err
);
  localparam int WORD  = 32;
  localparam int BIT_W = 5;
  localparam int FRAME = SLOTS * WORD;
  localparam int IDX_W = $clog2(FRAME) + 1;
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] cnt, inc, pos, bidx;
  logic [WORD-1:0]  word, txw, rx_sh, rx_word;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0] bis;
  logic synced, dbl, err, oe, du, dd_fall, take_q, last_q, valid_q;
  logic len_single, len_double, mode, in_frame, own, lead, sample;

  assign inc        = (&cnt) ? cnt : cnt + 1'b1;
  assign len_single = inc == CNT_W'(FRAME);
  assign len_double = inc == CNT_W'(2 * FRAME);
  assign mode       = (frame_sync && synced) ? (len_double | (dbl & ~len_single)) : dbl;
  assign pos        = frame_sync ? '0 : inc;
  assign bidx       = mode ? {1'b0, pos[CNT_W-1:1]} : pos;
  assign in_frame   = bidx < CNT_W'(FRAME);
  assign slot       = bidx[BIT_W +: SLOT_W];
  assign bis        = bidx[BIT_W-1:0];
  assign own        = in_frame && (slot == slot_sel);
  assign lead       = ~mode | ~pos[0];
  assign sample     = own & (~mode | pos[0]);
  assign word       = {tx_voice_a, tx_voice_b, tx_mon, tx_ci, ~tx_mr, ~tx_mx};

  always_ff @(negedge bit_clk or negedge rst_n)
    if (!rst_n) dd_fall <= 1'b0;
    else        dd_fall <= dn_data;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      synced  <= 1'b0;
      dbl     <= 1'b0;
      err     <= 1'b0;
      oe      <= 1'b0;
      du      <= 1'b1;
      txw     <= '0;
      take_q  <= 1'b0;
      last_q  <= 1'b0;
      rx_sh   <= '0;
      rx_word <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt <= pos;
      if (frame_sync) begin
        synced <= 1'b1;
        dbl    <= mode;
        if (synced && !len_single && !len_double) err <= 1'b1;
      end
      if (lead) begin
        oe <= own;
        du <= own ? ((bis == '0) ? word[WORD-1] : txw[~bis]) : 1'b1;
        if (own && bis == '0) txw <= word;
      end
      take_q  <= sample;
      last_q  <= &bis;
      if (take_q) rx_sh <= {rx_sh[WORD-2:0], dd_fall};
      valid_q <= take_q & last_q;
      if (take_q & last_q) rx_word <= {rx_sh[WORD-2:0], dd_fall};
    end
  end

  assign up_data    = du;
  assign up_oe      = oe;
  assign rx_voice_a = rx_word[31:24];
  assign rx_voice_b = rx_word[23:16];
  assign rx_mon     = rx_word[15:8];
  assign rx_ci      = rx_word[7:2];
  assign rx_mr      = ~rx_word[1];
  assign rx_mx      = ~rx_word[0];
  assign rx_valid   = valid_q;
  assign rate_dbl   = dbl;
  assign frame_err  = err;
endmodule

module gci_slot_xcvr_chk (
  input logic bit_clk,
  input logic rst_n,
  input logic frame_sync,
  input logic up_data,
  input logic up_oe,
  input logic rx_valid,
  input logic rate_dbl,
  input logic frame_err
);
  p_idle_high_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !up_oe |-> up_data);
  p_strobe_once_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_rate_at_sync_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !frame_sync |=> $stable(rate_dbl));
  p_err_sticky_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  p_err_at_sync_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !frame_sync |=> $stable(frame_err));
endmodule

bind gci_slot_xcvr gci_slot_xcvr_chk u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .frame_sync(frame_sync),
  .up_data(up_data), .up_oe(up_oe), .rx_valid(rx_valid),
  .rate_dbl(rate_dbl), .frame_err(frame_err)
);

// File: tb/sim_gci_slot_xcvr.sv
`timescale 1ns/1ps
module sim_gci_slot_xcvr;
  localparam int CLK_PERIOD = 8;

  logic bit_clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0, dn_data = 1'b0;
  logic [2:0] slot_sel = '0;
  logic [7:0] tx_voice_a = '0, tx_voice_b = '0, tx_mon = '0;
  logic [5:0] tx_ci = '0;
  logic tx_mr = 1'b0, tx_mx = 1'b0;
  logic up_data, up_oe, rx_mr, rx_mx, rx_valid, rate_dbl, frame_err;
  logic [7:0] rx_voice_a, rx_voice_b, rx_mon;
  logic [5:0] rx_ci;

  gci_slot_xcvr u0 (
    .bit_clk(bit_clk), .rst_n(rst_n), .frame_sync(frame_sync), .dn_data(dn_data),
    .slot_sel(slot_sel), .tx_voice_a(tx_voice_a), .tx_voice_b(tx_voice_b),
    .tx_mon(tx_mon), .tx_ci(tx_ci), .tx_mr(tx_mr), .tx_mx(tx_mx),
    .up_data(up_data), .up_oe(up_oe), .rx_voice_a(rx_voice_a),
    .rx_voice_b(rx_voice_b), .rx_mon(rx_mon), .rx_ci(rx_ci), .rx_mr(rx_mr),
    .rx_mx(rx_mx), .rx_valid(rx_valid), .rate_dbl(rate_dbl), .frame_err(frame_err)
  );

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  int total = 0, bad = 0, cycles = 0;
  int prev_len = 0;
  bit started = 0, m_dbl = 0, m_err = 0, due = 0;
  logic [31:0] cur_tx = '0, cap = '0, pend = '0;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge bit_clk) begin
    cycles++;
    if (cycles > 200000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic apply_tx(input logic [31:0] w);
    tx_voice_a = w[31:24]; tx_voice_b = w[23:16]; tx_mon = w[15:8];
    tx_ci = w[7:2]; tx_mr = ~w[1]; tx_mx = ~w[0];
    cur_tx = w;
  endtask

  task automatic check_outputs(input bit exp_oe, input bit exp_du);
    chk(up_oe == exp_oe, "R4 up_oe", up_oe, exp_oe);
    chk(up_data == exp_du, "R2 up_data", up_data, exp_du);
    chk(rx_valid == due, "R6 rx_valid", rx_valid, due);
    if (due) begin
      chk(rx_voice_a == pend[31:24], "R2 rx_voice_a", rx_voice_a, pend[31:24]);
      chk(rx_voice_b == pend[23:16], "R2 rx_voice_b", rx_voice_b, pend[23:16]);
      chk(rx_mon == pend[15:8], "R2 rx_mon", rx_mon, pend[15:8]);
      chk(rx_ci == pend[7:2], "R2 rx_ci", rx_ci, pend[7:2]);
      chk(rx_mr == ~pend[1], "R3 rx_mr", rx_mr, ~pend[1]);
      chk(rx_mx == ~pend[0], "R3 rx_mx", rx_mx, ~pend[0]);
    end
    due = 0;
    chk(rate_dbl == m_dbl, "R7 rate_dbl", rate_dbl, m_dbl);
    chk(frame_err == m_err, "R9 frame_err", frame_err, m_err);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      frame_sync = 1'b0;
      @(posedge bit_clk); #(CLK_PERIOD/4);
      check_outputs(1'b0, 1'b1);
    end
  endtask

  // R1 R5 R8: bench model of one frame of len edges with owned slot sel
  task automatic run_frame(input int len, input int sel);
    logic [31:0] dn [8];
    int start_k, last_k, b;
    bit e_oe, e_du;
    logic [31:0] w1, w2;
    for (int s = 0; s < 8; s++) dn[s] = $urandom;
    slot_sel = 3'(sel);
    if (started) begin
      if (prev_len == 512) m_dbl = 1;
      else if (prev_len == 256) m_dbl = 0;
      else m_err = 1;
    end
    started = 1;
    w1 = $urandom; w2 = $urandom;
    apply_tx(w1);
    start_k = m_dbl ? 64*sel : 32*sel;
    last_k  = m_dbl ? 2*(32*sel+31)+1 : 32*sel+31;
    for (int k = 0; k < len; k++) begin
      frame_sync = (k == 0);
      if (k == start_k + 2) apply_tx(w2);
      @(posedge bit_clk); #(CLK_PERIOD/4);
      b = m_dbl ? k/2 : k;
      if (k == start_k) cap = cur_tx;
      e_oe = (b < 256) && (b/32 == sel);
      e_du = e_oe ? cap[31 - (b % 32)] : 1'b1;
      check_outputs(e_oe, e_du);
      dn_data = (b < 256) ? dn[b/32][31 - (b % 32)] : 1'b0;
      if (k == last_k) begin
        due = 1;
        pend = dn[sel];
      end
    end
    frame_sync = 1'b0;
    prev_len = len;
  endtask

  initial begin
    repeat (3) @(posedge bit_clk);
    #(CLK_PERIOD/4);
    // R10: reset values
    chk(up_oe == 1'b0, "R10 up_oe in reset", up_oe, 0);
    chk(up_data == 1'b1, "R10 up_data in reset", up_data, 1);
    chk(rx_valid == 1'b0, "R10 rx_valid in reset", rx_valid, 0);
    chk(rate_dbl == 1'b0, "R10 rate_dbl in reset", rate_dbl, 0);
    chk(frame_err == 1'b0, "R10 frame_err in reset", frame_err, 0);
    rst_n = 1'b1;
    idle(6);                 // R10: nothing driven before first sync
    run_frame(256, 0);       // R1 R2 R3 R5 first slot
    run_frame(256, 3);
    run_frame(256, 7);       // R6 strobe lands on next sync edge
    run_frame(512, 7);       // R7 still single while first long frame is measured
    run_frame(512, 7);       // R8 double rate, last slot
    run_frame(512, 2);
    run_frame(512, 0);
    run_frame(256, 5);       // R7 short frame still paced at double rate
    run_frame(256, 4);       // R7 back to single
    run_frame(256, 6);
    run_frame(300, 1);       // R9 late sync
    run_frame(256, 1);
    run_frame(200, 2);       // R9 early sync
    run_frame(256, 2);
    run_frame(256, 0);
    idle(4);
    summary();
  end
endmodule